// File: doc/BRIEF.md
# Precision-Time Event Timestamp Capture Bank

This block sits beside a packet datapath and a free-running 64-bit nanosecond clock. When the datapath flags a timing event, the block copies the clock value into a holding slot. Software collects it later through a small register port.

There are four receive slots and one transmit slot. Each receive event names the slot it targets. A slot that holds a value is locked and ignores new captures until software reads its upper word, which both returns the data and frees the slot. Receive events first pass a configurable filter on the message version, the message class and whether the message was carried over UDP. Captures that hit a locked slot are lost and raise a sticky overflow flag. A level interrupt reports a held transmit timestamp when software enables it.

Top module: `ptp_ts_latch_bank`

## Requirements
- R1: After reset every slot is free, the status word reads 0, the overflow flag is clear, `irq_o` is low and `rd_data_o` is 0.
- R2: A receive event that passes the filter and targets a free slot stores the `time_i` value present in the event cycle. From the next cycle the slot's status bit (bit k for slot k) is set.
- R3: Register reads return data on `rd_data_o` one cycle after the read strobe. Receive slot k has its low word at address 4+2k and its high word at 5+2k. Reading a low word changes nothing. Reading a high word returns bits 63:32 and frees the slot.
- R4: A capture aimed at a locked slot is dropped and the stored value is unchanged.
- R5: A dropped capture sets the overflow flag, status bit 5. Reading the status word at address 2 clears the flag. A drop in the same cycle as that read leaves the flag set.
- R6: When all four receive slots are locked, every receive capture is dropped. A slot freed by reading its high word accepts the next capture.
- R7: The receive configuration register is at address 1. Bit 0 enables capture. Bits 2:1 select the message version, which must equal `rx_ver_i` for a capture to happen. With bit 0 clear, no receive capture happens.
- R8: When bit 3 of the receive configuration is set, events with `rx_type_i[3]` = 1 are rejected. When bit 4 is clear, events with `rx_udp_i` = 1 are rejected.
- R9: A transmit event stores `time_i` in the transmit slot and sets status bit 4. The slot's low word is at address 12 and its high word at 13. Reading the high word frees the slot. A transmit event that finds the slot locked is dropped and sets the overflow flag.
- R10: `irq_o` is high exactly while control bit 0 (address 0) is set and the transmit slot is locked.
- R11: The control and receive configuration registers read back what was written. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current clock time in nanoseconds |
| rx_evt_i | input | 1 | Receive timing event strobe |
| rx_slot_i | input | 2 | Receive slot targeted by the event |
| rx_ver_i | input | 4 | Message version of the receive event |
| rx_type_i | input | 4 | Message type of the receive event |
| rx_udp_i | input | 1 | Receive event carried over UDP |
| tx_evt_i | input | 1 | Transmit timing event strobe |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data, one cycle after the strobe |
| irq_o | output | 1 | Transmit timestamp interrupt |

## Verification
The assertions check several rules on every cycle:
- a locked slot stays locked and keeps its value until its high word is read;
- a high-word read frees a locked slot;
- every drop leaves the overflow flag set;
- a disabled filter lets no capture through;
- the interrupt only rises after a transmit event or a register write.

Only the bench scenarios can show the values involved:
- that the stored value is the one present in the event cycle;
- that low-word reads leave the status unchanged;
- the version, class and UDP filter outcomes;
- that a drop beats a same-cycle status read;
- that capture stalls when all four slots are full and resumes after a release.

// File: rtl/ptp_tsl_pkg.sv
package ptp_tsl_pkg;

  localparam int unsigned ADR_CTRL    = 0;
  localparam int unsigned ADR_RXCFG   = 1;
  localparam int unsigned ADR_STATUS  = 2;
  localparam int unsigned ADR_RX_BASE = 4;

  typedef struct packed {
    logic       udp_en;
    logic       type_en;
    logic [1:0] ver;
    logic       cap_en;
  } rxcfg_t;

  localparam int unsigned RXCFG_W = $bits(rxcfg_t);

endpackage

// File: rtl/ts_rx_filter.sv
module ts_rx_filter
  import ptp_tsl_pkg::*;
#(
  parameter int unsigned VER_W  = 4,
  parameter int unsigned TYPE_W = 4
) (
  input  rxcfg_t            cfg_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              udp_i,
  output logic              pass_o
);

  localparam int unsigned SEL_W = $bits(cfg_i.ver);

  logic ver_ok;
  logic type_ok;
  logic udp_ok;

  always_comb begin
    ver_ok  = (ver_i == VER_W'(cfg_i.ver));
    // the top bit of the type field marks a general (non-event) message
    type_ok = !cfg_i.type_en || !type_i[TYPE_W-1];
    udp_ok  = cfg_i.udp_en || !udp_i;
    pass_o  = cfg_i.cap_en && ver_ok && type_ok && udp_ok;
  end

  if (SEL_W > VER_W) begin : g_bad_width
    initial $error("version select wider than event version");
  end

endmodule

// File: rtl/ts_slot.sv
module ts_slot #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [TS_W-1:0] time_i,
  input  logic            rel_i,
  output logic            locked_o,
  output logic [TS_W-1:0] ts_o,
  output logic            drop_o
);

  logic            locked_q, locked_n;
  logic [TS_W-1:0] ts_q, ts_n;
  logic            take;

  always_comb begin
    take     = cap_i && !locked_q;
    drop_o   = cap_i && locked_q;
    locked_n = locked_q;
    ts_n     = ts_q;
    if (take) begin
      locked_n = 1'b1;
      ts_n     = time_i;
    end else if (rel_i) begin
      locked_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else begin
      locked_q <= locked_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
    end else if (take) begin
      ts_q <= ts_n;
    end
  end

  assign locked_o = locked_q;
  assign ts_o     = ts_q;

  // R4: a held value survives further captures
  p_hold_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(ts_q));

  // R4: only a high-word read frees the slot
  p_hold_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !rel_i) |=> locked_q);

  // R3: a high-word read frees a locked slot
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && rel_i) |=> !locked_q);

endmodule

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ptp_tsl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              irq_en_o,
  output rxcfg_t            rxcfg_o
);

  logic   irq_en_q, irq_en_n, irq_en_we;
  rxcfg_t rxcfg_q, rxcfg_n;
  logic   rxcfg_we;

  always_comb begin
    irq_en_we = wr_i && (addr_i == ADDR_W'(ADR_CTRL));
    rxcfg_we  = wr_i && (addr_i == ADDR_W'(ADR_RXCFG));
    irq_en_n  = wdata_i[0];
    rxcfg_n   = rxcfg_t'(wdata_i[RXCFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
    end else if (irq_en_we) begin
      irq_en_q <= irq_en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxcfg_q <= '0;
    end else if (rxcfg_we) begin
      rxcfg_q <= rxcfg_n;
    end
  end

  assign irq_en_o = irq_en_q;
  assign rxcfg_o  = rxcfg_q;

  // R11: a control write lands in the register
  p_ctrl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_we |=> (irq_en_q == $past(wdata_i[0])));

endmodule

// File: rtl/ptp_ts_latch_bank.sv
module ptp_ts_latch_bank
  import ptp_tsl_pkg::*;
#(
  parameter int unsigned TS_W   = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM_RX = 4,
  parameter int unsigned VER_W  = 4,
  parameter int unsigned TYPE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TS_W-1:0]           time_i,
  input  logic                      rx_evt_i,
  input  logic [$clog2(NUM_RX)-1:0] rx_slot_i,
  input  logic [VER_W-1:0]          rx_ver_i,
  input  logic [TYPE_W-1:0]         rx_type_i,
  input  logic                      rx_udp_i,
  input  logic                      tx_evt_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic [REG_W-1:0]          rd_data_o,
  output logic                      irq_o
);

  localparam int unsigned SLOT_W  = $clog2(NUM_RX);
  localparam int unsigned NSLOT   = NUM_RX + 1;
  localparam int unsigned TX_IDX  = NUM_RX;
  localparam int unsigned TX_BASE = ADR_RX_BASE + 2 * NUM_RX;
  localparam int unsigned OVF_BIT = NUM_RX + 1;

  rxcfg_t            rxcfg;
  logic              irq_en;
  logic              rx_pass;
  logic [NSLOT-1:0]  cap;
  logic [NSLOT-1:0]  rel;
  logic [NSLOT-1:0]  locked;
  logic [NSLOT-1:0]  drop;
  logic [TS_W-1:0]   ts [NSLOT];
  logic              any_drop;
  logic              stat_rd;
  logic              ovf_q, ovf_n;
  logic [REG_W-1:0]  rdata_q, rdata_n;

  ts_cfg_regs #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wr_data_i),
    .irq_en_o (irq_en),
    .rxcfg_o  (rxcfg)
  );

  ts_rx_filter #(
    .VER_W  (VER_W),
    .TYPE_W (TYPE_W)
  ) u_filt (
    .cfg_i  (rxcfg),
    .ver_i  (rx_ver_i),
    .type_i (rx_type_i),
    .udp_i  (rx_udp_i),
    .pass_o (rx_pass)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k == TX_IDX) begin : g_tx
      assign cap[k] = tx_evt_i;
    end else begin : g_rx
      assign cap[k] = rx_evt_i && rx_pass && (rx_slot_i == SLOT_W'(k));
    end
    assign rel[k] = rd_i && (addr_i == ADDR_W'(ADR_RX_BASE + 2 * k + 1));

    ts_slot #(
      .TS_W (TS_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap[k]),
      .time_i   (time_i),
      .rel_i    (rel[k]),
      .locked_o (locked[k]),
      .ts_o     (ts[k]),
      .drop_o   (drop[k])
    );
  end

  // overflow flag: set beats clear-on-read
  always_comb begin
    any_drop = |drop;
    stat_rd  = rd_i && (addr_i == ADDR_W'(ADR_STATUS));
    ovf_n    = ovf_q;
    if (any_drop) begin
      ovf_n = 1'b1;
    end else if (stat_rd) begin
      ovf_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_n;
    end
  end

  // read data mux
  always_comb begin
    rdata_n = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) begin
      rdata_n[0] = irq_en;
    end else if (addr_i == ADDR_W'(ADR_RXCFG)) begin
      rdata_n[RXCFG_W-1:0] = rxcfg;
    end else if (addr_i == ADDR_W'(ADR_STATUS)) begin
      rdata_n[NSLOT-1:0] = locked;
      rdata_n[OVF_BIT]   = ovf_q;
    end
    for (int k = 0; k < NSLOT; k++) begin
      if (addr_i == ADDR_W'(ADR_RX_BASE + 2 * k)) begin
        rdata_n = ts[k][REG_W-1:0];
      end else if (addr_i == ADDR_W'(ADR_RX_BASE + 2 * k + 1)) begin
        rdata_n = ts[k][TS_W-1:REG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_n;
    end
  end

  assign rd_data_o = rdata_q;
  assign irq_o     = irq_en && locked[TX_IDX];

  if (TS_W != 2 * REG_W || TX_BASE + 2 > (1 << ADDR_W) || OVF_BIT >= REG_W)
  begin : g_bad_cfg
    initial $error("parameter set does not fit the register map");
  end

  // R5: every drop leaves the flag set
  p_drop_sets_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_drop |=> ovf_q);

  // R5: a status read with no drop clears the flag
  p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !any_drop) |=> !ovf_q);

  // R7: with capture disabled no receive slot is loaded
  p_filter_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rxcfg.cap_en |-> (cap[NUM_RX-1:0] == '0));

  // R10: interrupt only rises after a transmit event or a write
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(tx_evt_i) || $past(wr_i)));

  // R2: at most one receive slot captures per event
  p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap[NUM_RX-1:0]));

endmodule

// File: tb/ptp_ts_latch_bank_tb.sv
module ptp_ts_latch_bank_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [63:0] time_i;
  logic        rx_evt_i;
  logic [1:0]  rx_slot_i;
  logic [3:0]  rx_ver_i;
  logic [3:0]  rx_type_i;
  logic        rx_udp_i;
  logic        tx_evt_i;
  logic        wr_i;
  logic        rd_i;
  logic [3:0]  addr_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_chk;
  int n_bad;

  ptp_ts_latch_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_i    (time_i),
    .rx_evt_i  (rx_evt_i),
    .rx_slot_i (rx_slot_i),
    .rx_ver_i  (rx_ver_i),
    .rx_type_i (rx_type_i),
    .rx_udp_i  (rx_udp_i),
    .tx_evt_i  (tx_evt_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic rx_ev(input logic [1:0] s, input logic [3:0] v, input logic [3:0] ty,
                       input logic u, input logic [63:0] t);
    @(negedge clk);
    rx_evt_i = 1'b1; rx_slot_i = s; rx_ver_i = v; rx_type_i = ty; rx_udp_i = u; time_i = t;
    @(negedge clk);
    rx_evt_i = 1'b0; time_i = 64'hdead_beef_0bad_f00d;
  endtask

  task automatic tx_ev(input logic [63:0] t);
    @(negedge clk);
    tx_evt_i = 1'b1; time_i = t;
    @(negedge clk);
    tx_evt_i = 1'b0; time_i = 64'hdead_beef_0bad_f00d;
  endtask

  task automatic free_all();
    logic [31:0] d;
    for (int k = 0; k < 5; k++) reg_rd(4'(5 + 2 * k), d);
    reg_rd(4'd2, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rd_data after reset", rd_data_o, 32'h0);
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    reg_rd(4'd2, d);
    chk("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    reg_wr(4'd1, 32'h1D);
    reg_rd(4'd1, d);
    chk("R11 rxcfg readback", d, 32'h1D);
    reg_wr(4'd0, 32'h0);
    reg_rd(4'd0, d);
    chk("R11 ctrl readback", d, 32'h0);
    reg_wr(4'd2, 32'hFF);
    reg_wr(4'd5, 32'hFFFF_FFFF);
    reg_rd(4'd2, d);
    chk("R11 status write ignored", d, 32'h0);
    reg_rd(4'd5, d);
    chk("R11 slot write ignored", d, 32'h0);
  endtask

  task automatic t_rx_basic();
    logic [31:0] d;
    rx_ev(2'd2, 4'd2, 4'd0, 1'b0, 64'h1122_3344_5566_7788);
    reg_rd(4'd2, d);
    chk("R2 status slot2", d, 32'h04);
    reg_rd(4'd8, d);
    chk("R3 slot2 low", d, 32'h5566_7788);
    reg_rd(4'd2, d);
    chk("R3 low read keeps lock", d, 32'h04);
    reg_rd(4'd9, d);
    chk("R3 slot2 high", d, 32'h1122_3344);
    reg_rd(4'd2, d);
    chk("R3 high read frees", d, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    rx_ev(2'd1, 4'd2, 4'd1, 1'b0, 64'hAAAA_0001_AAAA_0002);
    rx_ev(2'd1, 4'd2, 4'd1, 1'b0, 64'hBBBB_0001_BBBB_0002);
    reg_rd(4'd2, d);
    chk("R5 overflow after drop", d, 32'h22);
    reg_rd(4'd2, d);
    chk("R5 overflow cleared by read", d, 32'h02);
    reg_rd(4'd6, d);
    chk("R4 first value kept low", d, 32'hAAAA_0002);
    reg_rd(4'd7, d);
    chk("R4 first value kept high", d, 32'hAAAA_0001);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    rx_ev(2'd0, 4'd2, 4'd0, 1'b0, 64'h0000_0C0C_0000_0C0D);
    @(negedge clk);
    rx_evt_i = 1'b1; rx_slot_i = 2'd0; time_i = 64'h1;
    rd_i = 1'b1; addr_i = 4'd2;
    @(negedge clk);
    rx_evt_i = 1'b0; rd_i = 1'b0;
    chk("R5 status read beside drop", rd_data_o, 32'h01);
    reg_rd(4'd2, d);
    chk("R5 set wins over clear", d, 32'h21);
    reg_rd(4'd4, d);
    chk("R4 slot0 kept", d, 32'h0000_0C0D);
    free_all();
  endtask

  task automatic t_stall();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) rx_ev(2'(k), 4'd2, 4'd0, 1'b0, 64'(k + 16));
    rx_ev(2'd3, 4'd2, 4'd0, 1'b0, 64'h77);
    reg_rd(4'd2, d);
    chk("R6 all full plus drop", d, 32'h2F);
    reg_rd(4'd10, d);
    chk("R6 stalled slot kept", d, 32'd19);
    reg_rd(4'd11, d);
    rx_ev(2'd3, 4'd2, 4'd0, 1'b0, 64'h0000_0005_0000_00EE);
    reg_rd(4'd10, d);
    chk("R6 resumes after release", d, 32'h0000_00EE);
    free_all();
    reg_rd(4'd2, d);
    chk("R6 all freed", d, 32'h0);
  endtask

  task automatic t_filter();
    logic [31:0] d;
    reg_wr(4'd1, 32'h1C);
    rx_ev(2'd0, 4'd2, 4'd0, 1'b0, 64'h9);
    reg_rd(4'd2, d);
    chk("R7 capture disabled", d, 32'h0);
    reg_wr(4'd1, 32'h1D);
    rx_ev(2'd0, 4'd1, 4'd0, 1'b0, 64'h9);
    reg_rd(4'd2, d);
    chk("R7 version mismatch", d, 32'h0);
    reg_wr(4'd1, 32'h1B);
    rx_ev(2'd0, 4'd1, 4'd0, 1'b0, 64'h9);
    reg_rd(4'd2, d);
    chk("R7 version 1 accepted", d, 32'h01);
    free_all();
    reg_wr(4'd1, 32'h1D);
    rx_ev(2'd1, 4'd2, 4'd9, 1'b0, 64'h9);
    reg_rd(4'd2, d);
    chk("R8 general type rejected", d, 32'h0);
    reg_wr(4'd1, 32'h15);
    rx_ev(2'd1, 4'd2, 4'd9, 1'b0, 64'h9);
    reg_rd(4'd2, d);
    chk("R8 type filter off accepts", d, 32'h02);
    free_all();
    reg_wr(4'd1, 32'h0D);
    rx_ev(2'd2, 4'd2, 4'd0, 1'b1, 64'h9);
    reg_rd(4'd2, d);
    chk("R8 udp rejected", d, 32'h0);
    reg_wr(4'd1, 32'h1D);
    rx_ev(2'd2, 4'd2, 4'd0, 1'b1, 64'h9);
    reg_rd(4'd2, d);
    chk("R8 udp accepted", d, 32'h04);
    free_all();
  endtask

  task automatic t_tx();
    logic [31:0] d;
    reg_wr(4'd0, 32'h0);
    tx_ev(64'h0102_0304_0506_0708);
    reg_rd(4'd2, d);
    chk("R9 tx status", d, 32'h10);
    chk("R10 irq masked", {31'b0, irq_o}, 32'h0);
    reg_wr(4'd0, 32'h1);
    chk("R10 irq enabled", {31'b0, irq_o}, 32'h1);
    tx_ev(64'h5);
    reg_rd(4'd2, d);
    chk("R9 tx drop overflow", d, 32'h30);
    reg_rd(4'd12, d);
    chk("R9 tx low", d, 32'h0506_0708);
    reg_rd(4'd13, d);
    chk("R9 tx high", d, 32'h0102_0304);
    chk("R10 irq after release", {31'b0, irq_o}, 32'h0);
    reg_rd(4'd2, d);
    chk("R9 tx freed", d, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; time_i = '0; rx_evt_i = 1'b0; rx_slot_i = '0; rx_ver_i = '0;
    rx_type_i = '0; rx_udp_i = 1'b0; tx_evt_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_rx_basic();
    t_lock();
    t_set_wins();
    t_stall();
    t_filter();
    t_tx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule